// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides a WIDTH-bit dividend by a WIDTH-bit divisor. It produces one quotient bit per clock cycle and uses a single subtractor one bit wider than the operands. A one-cycle `start` strobe captures the operands and the operand mode. After WIDTH further clock edges the quotient and remainder are final, and `ready` pulses for exactly one cycle.

Internally a partial-remainder register and a dividend/quotient register shift left together as one double-width register. Each step subtracts the divisor from the upper half. A non-negative trial difference replaces the upper half and shifts a 1 into the quotient. A negative one keeps the upper half and shifts in a 0.

With `signed_mode` high, both operands are two's complement. They are reduced to magnitudes at load time, and the stored magnitude results are corrected on the way out. A zero divisor is not detected.

Top module: `seq_divider`

## Requirements
- R1: After reset, `ready` is 0, and `quotient` and `remainder` read 0 until the first `start`.
- R2: With `signed_mode` = 0 (unsigned), the final `quotient` is floor(dividend / divisor) and `remainder` is dividend − quotient × divisor.
- R3: `ready` is high for exactly one cycle. It rises after the WIDTH-th rising edge that follows the edge at which `start` was sampled high.
- R4: After `ready`, `quotient` and `remainder` hold their values until the next `start`, whatever the operand inputs do.
- R5: With `signed_mode` = 1, the quotient is rounded toward zero. It is negative exactly when one of the two operands is negative.
- R6: With `signed_mode` = 1, a nonzero remainder has the sign of the dividend, so dividend = quotient × divisor + remainder.
- R7: A `start` sampled while a division is running abandons it. No `ready` is produced for the abandoned operation, and the new one completes WIDTH edges after the new `start`.
- R8: A divisor larger than the dividend gives quotient 0 with the dividend as remainder. Equal operands give quotient 1 and remainder 0.
- R9: With `signed_mode` = 0, the operand MSB is a magnitude bit (for example 0xF0 / 0x03 = 0x50).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin a division |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, sampled with `start` |
| divisor | input | WIDTH | Divisor, sampled with `start` |
| quotient | output | WIDTH | Quotient, valid from `ready` until next `start` |
| remainder | output | WIDTH | Remainder, valid from `ready` until next `start` |
| ready | output | 1 | One-cycle pulse when the result is final |

## Verification
Operands are captured at the edge that samples `start`. The results and the `ready` pulse are due exactly WIDTH edges later, and `ready` is low again one edge after that. The bench drives inputs on falling edges and counts falling edges from the load edge until `ready` appears. It requires that count to equal WIDTH, then compares the results at that same falling edge. After the pulse it scrambles the operand inputs and rechecks `ready` and the held results several cycles later. For the abandoned division it also checks that no `ready` appears before the restarted operation is due.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;

    // Sign corrections applied to the magnitude results at the output.
    typedef struct packed {
        logic neg_quot;
        logic neg_rem;
    } sign_fix_t;

    typedef enum logic [1:0] {
        OPC_IDLE = 2'd0,
        OPC_LOAD = 2'd1,
        OPC_STEP = 2'd2
    } div_op_e;

    // The quotient is negative when exactly one operand is negative.
    function automatic sign_fix_t make_fix(input logic is_signed,
                                           input logic dvd_msb,
                                           input logic dvs_msb);
        sign_fix_t f;
        f.neg_quot = is_signed & (dvd_msb ^ dvs_msb);
        f.neg_rem  = is_signed & dvd_msb;
        return f;
    endfunction

endpackage

// File: rtl/seq_div_prep.sv
module seq_div_prep
    import seq_div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         is_signed,
    input  logic [W-1:0] dvd_in,
    input  logic [W-1:0] dvs_in,
    output logic [W-1:0] dvd_mag,
    output logic [W-1:0] dvs_mag,
    output sign_fix_t    fix
);

    logic dvd_neg;
    logic dvs_neg;

    assign dvd_neg = is_signed & dvd_in[W-1];
    assign dvs_neg = is_signed & dvs_in[W-1];

    always_comb begin
        dvd_mag = dvd_neg ? (~dvd_in + 1'b1) : dvd_in;
        dvs_mag = dvs_neg ? (~dvs_in + 1'b1) : dvs_in;
        fix     = make_fix(is_signed, dvd_in[W-1], dvs_in[W-1]);
    end

endmodule

// File: rtl/seq_div_step.sv
module seq_div_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);

    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         borrow;
    logic         unused_hi;

    assign shifted = {rem_in, quo_in[W-1]};
    assign {borrow, diff} = {1'b0, shifted} - {2'b00, dvs};
    assign unused_hi = ^{diff[W], shifted[W]};

    always_comb begin
        if (!borrow) begin
            rem_out = diff[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b1};
        end else begin
            rem_out = shifted[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/seq_div_fix.sv
module seq_div_fix
    import seq_div_pkg::*;
#(
    parameter int W = 8
) (
    input  sign_fix_t    fix,
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out
);

    always_comb begin
        quo_out = fix.neg_quot ? (~quo_mag + 1'b1) : quo_mag;
        rem_out = fix.neg_rem  ? (~rem_mag + 1'b1) : rem_mag;
    end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import seq_div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             ready
);

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] STEPS = CW'(WIDTH);

    logic [WIDTH-1:0] p_q, a_q, b_q;
    logic [CW-1:0]    cnt_q;
    sign_fix_t        fix_q;
    logic             ready_q;

    logic [WIDTH-1:0] dvd_mag, dvs_mag;
    sign_fix_t        fix_new;
    logic [WIDTH-1:0] p_nxt, a_nxt;
    div_op_e          op;

    seq_div_prep #(.W(WIDTH)) u_prep (
        .is_signed (signed_mode),
        .dvd_in    (dividend),
        .dvs_in    (divisor),
        .dvd_mag   (dvd_mag),
        .dvs_mag   (dvs_mag),
        .fix       (fix_new)
    );

    seq_div_step #(.W(WIDTH)) u_step (
        .rem_in  (p_q),
        .quo_in  (a_q),
        .dvs     (b_q),
        .rem_out (p_nxt),
        .quo_out (a_nxt)
    );

    seq_div_fix #(.W(WIDTH)) u_fix (
        .fix     (fix_q),
        .quo_mag (a_q),
        .rem_mag (p_q),
        .quo_out (quotient),
        .rem_out (remainder)
    );

    always_comb begin
        if (start)              op = OPC_LOAD;
        else if (cnt_q != '0)   op = OPC_STEP;
        else                    op = OPC_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q     <= '0;
            a_q     <= '0;
            b_q     <= '0;
            cnt_q   <= '0;
            fix_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            unique case (op)
                OPC_LOAD: begin
                    p_q     <= '0;
                    a_q     <= dvd_mag;
                    b_q     <= dvs_mag;
                    fix_q   <= fix_new;
                    cnt_q   <= STEPS;
                    ready_q <= 1'b0;
                end
                OPC_STEP: begin
                    p_q     <= p_nxt;
                    a_q     <= a_nxt;
                    cnt_q   <= cnt_q - 1'b1;
                    ready_q <= (cnt_q == CW'(1));
                end
                default: begin
                    ready_q <= 1'b0;
                end
            endcase
        end
    end

    assign ready = ready_q;

endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
    parameter int W = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start,
    input logic                       ready,
    input logic [$clog2(W+1)-1:0]     cnt,
    input logic [W-1:0]               quotient,
    input logic [W-1:0]               remainder
);

    localparam int CW = $clog2(W + 1);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    a_r7_restart_reload: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == CW'(W)) && !ready);

    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !start) |=> cnt == $past(cnt) - CW'(1));

    a_r3_ready_due: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(1) && !start) |=> ready);

    a_r3_ready_idle: assert property (@(posedge clk) disable iff (rst)
        ready |-> cnt == '0);

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !start) |=> $stable(quotient) && $stable(remainder));

endmodule

bind seq_divider seq_divider_chk #(.W(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ready     (ready),
    .cnt       (cnt_q),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       signed_mode;
    logic [7:0] dividend;
    logic [7:0] divisor;
    logic [7:0] quotient;
    logic [7:0] remainder;
    logic       ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    seq_divider #(.WIDTH(8)) i_seq_divider (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .signed_mode (signed_mode),
        .dividend    (dividend),
        .divisor     (divisor),
        .quotient    (quotient),
        .remainder   (remainder),
        .ready       (ready)
    );

    // {signed, dividend, divisor, expected quotient, expected remainder}
    localparam int NV = 12;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'd100, 8'd7,   8'd14,  8'd2},
        {1'b0, 8'd255, 8'd16,  8'd15,  8'd15},
        {1'b0, 8'hF0,  8'h03,  8'h50,  8'h00},
        {1'b0, 8'd5,   8'd9,   8'd0,   8'd5},
        {1'b0, 8'd77,  8'd77,  8'd1,   8'd0},
        {1'b0, 8'd255, 8'd1,   8'd255, 8'd0},
        {1'b1, 8'hF9,  8'h02,  8'hFD,  8'hFF},
        {1'b1, 8'h07,  8'hFE,  8'hFD,  8'h01},
        {1'b1, 8'hF9,  8'hFE,  8'h03,  8'hFF},
        {1'b1, 8'h64,  8'h07,  8'h0E,  8'h02},
        {1'b1, 8'h80,  8'h03,  8'hD6,  8'hFE},
        {1'b1, 8'h05,  8'h09,  8'h00,  8'h05}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_div(input logic s, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] eq, input logic [7:0] er, input string tag);
        int  n;
        bit  got;
        logic [7:0] hq;
        logic [7:0] hr;
        @(negedge clk);
        start = 1'b1; signed_mode = s; dividend = a; divisor = b;
        @(negedge clk);
        start = 1'b0; signed_mode = ~s; dividend = ~a; divisor = 8'h5A;
        n = 0; got = 0;
        while (!got && n < 40) begin
            if (ready) got = 1;
            else begin
                @(negedge clk);
                n++;
            end
        end
        chk(n == 8, "R3 ready latency", n, 8);
        chk(quotient == eq, {tag, " quotient"}, quotient, eq);
        chk(remainder == er, {tag, " remainder"}, remainder, er);
        hq = quotient; hr = remainder;
        @(negedge clk);
        chk(ready == 1'b0, "R3 pulse width", ready, 0);
        dividend = 8'h3C; divisor = 8'h11;
        repeat (4) @(negedge clk);
        chk(quotient == hq && remainder == hr, "R4 hold",
            {quotient, remainder}, {hq, hr});
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; signed_mode = 1'b0; dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(ready == 1'b0, "R1 ready", ready, 0);
        chk(quotient == 8'd0, "R1 quotient", quotient, 0);
        chk(remainder == 8'd0, "R1 remainder", remainder, 0);

        // Vector table: R2, R8, R9 unsigned; R5, R6 signed
        for (int i = 0; i < NV; i++) begin
            run_div(VEC[i][32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
                    VEC[i][32] ? "R5/R6" : "R2/R8/R9");
        end

        // R7: restart while running
        @(negedge clk);
        start = 1'b1; signed_mode = 1'b0; dividend = 8'd200; divisor = 8'd3;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(ready == 1'b0, "R7 no ready before restart", ready, 0);
        end
        run_div(1'b0, 8'd50, 8'd7, 8'd7, 8'd1, "R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule